// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block works out where the operand of a 16-bit load/store instruction lives. The decode stage gives it a start pulse, a 4-bit mode code, the two register values it has read, the register number of the base, the incremented PC and the offset, address and constant fields of the instruction. One clock later the block answers with a location class and a result word. The location class says whether the operand is a register, a constant from the instruction, or a word in memory. The result word is the register number, the constant or the effective address (EA).

Most modes finish in a single cycle. Memory-indirect mode needs one extra read. The block first builds a pointer address from the incremented PC and the 9-bit offset. It holds a request on a request/valid memory port until the memory answers. The word that comes back becomes the EA. Auto-increment mode also returns a write-back for the base register, holding the base value plus the operand size.

Top module: `ea_gen`

## Requirements
- R1: After synchronous reset, `done`, `busy`, `mem_req`, `wb_en` and `err` are all low.
- R2: Mode code 0 (register): `done` rises one cycle after `start`. `loc` is 0 (register) and `result` is `base_sel` zero-extended. No memory request is made.
- R3: Mode code 1 (immediate): `done` one cycle after `start`, with `loc` 1 (instruction) and `result` equal to `imm_val`. No memory request is made.
- R4: Mode code 2 (register indirect): `done` one cycle after `start`, with `loc` 2 (memory) and `result` equal to `base_val`.
- R5: Mode code 3 (base plus displacement): `result` is `base_val` plus the 6-bit `disp`, sign-extended, modulo 2^16. `loc` is 2.
- R6: Mode code 4 (absolute): `result` equals `abs_addr`, and `loc` is 2.
- R7: Mode code 5 (PC-relative): `result` is `pc_next` plus the 9-bit `pc_ofs`, sign-extended, modulo 2^16. `loc` is 2.
- R8: Mode code 6 (indexed): `result` is `base_val` plus `index_val`, modulo 2^16. `loc` is 2.
- R9: Mode code 7 (auto-increment): `result` equals `base_val` and `loc` is 2. In the same cycle as `done`, `wb_en` is high, `wb_sel` equals `base_sel` and `wb_data` equals `base_val` plus OP_SIZE (1 by default). `wb_en` is low in all other cases.
- R10: Mode code 8 (memory indirect): one cycle after `start`, `mem_req` and `busy` are high and `mem_addr` is `pc_next` plus the sign-extended `pc_ofs`. Both stay high, with `mem_addr` unchanged, until `mem_valid` is sampled. One cycle after that, `done` is high, `result` equals the `mem_rdata` captured with `mem_valid`, `loc` is 2, and `busy` and `mem_req` are low.
- R11: Mode codes 9 to 15: `done` and `err` are high one cycle after `start`. `result` is 0 and no memory request is made.
- R12: A `start` that arrives while `busy` is high is ignored. It produces no extra `done` and does not disturb the outstanding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one computation |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 3 | Number of the base register |
| base_val | input | 16 | Contents of the base register |
| index_val | input | 16 | Contents of the index register |
| pc_next | input | 16 | Address of the next instruction |
| pc_ofs | input | 9 | PC offset field |
| disp | input | 6 | Base displacement field |
| abs_addr | input | 16 | Absolute address field |
| imm_val | input | 16 | Constant carried by the instruction |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_valid | input | 1 | Pointer read data valid |
| mem_rdata | input | 16 | Pointer read data |
| busy | output | 1 | Pointer read outstanding |
| done | output | 1 | Result valid, one-cycle pulse |
| err | output | 1 | Unused mode code (with done) |
| loc | output | 2 | Operand location: 0 register, 1 instruction, 2 memory |
| result | output | 16 | Register number, constant or EA |
| wb_en | output | 1 | Base register write-back enable |
| wb_sel | output | 3 | Register to write back |
| wb_data | output | 16 | Incremented base value |

## Verification
Every single-cycle mode, including the error codes, raises `done` in the first clock after `start` is sampled. Memory-indirect mode raises `mem_req` in that first clock and raises `done` in the clock after `mem_valid` is sampled. The bench drives inputs and samples outputs on the falling edge. A driver queues the expected result for every issued start. A monitor pops one entry on each falling edge where `done` is high, so a missing or extra `done` shows up as a queue mismatch. The memory model answers after a fixed three-cycle wait. It checks the request address in the cycle right after `start` and checks that the address holds steady for the whole wait.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_REG  = 4'd0,
    M_IMM  = 4'd1,
    M_RIND = 4'd2,
    M_BDSP = 4'd3,
    M_ABS  = 4'd4,
    M_PCR  = 4'd5,
    M_IDX  = 4'd6,
    M_AINC = 4'd7,
    M_MIND = 4'd8
  } mode_e;

  typedef enum logic [1:0] {
    LOC_REG  = 2'd0,
    LOC_INSN = 2'd1,
    LOC_MEM  = 2'd2
  } loc_e;
endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int EXT_W = OUT_W - IN_W;
  generate
    if (EXT_W > 0) begin : g_ext
      assign dout = {{EXT_W{din[IN_W-1]}}, din};
    end else begin : g_trunc
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW      = 16,
  parameter int PCOFS_W = 9,
  parameter int DISP_W  = 6,
  parameter int RSEL_W  = 3,
  parameter int OP_SIZE = 1
) (
  input  logic [3:0]        mode,
  input  logic [RSEL_W-1:0] base_sel,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     index_val,
  input  logic [AW-1:0]     pc_next,
  input  logic [PCOFS_W-1:0] pc_ofs,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     abs_addr,
  input  logic [AW-1:0]     imm_val,
  output logic [AW-1:0]     result,
  output loc_e              loc,
  output logic              bad,
  output logic              indirect,
  output logic [AW-1:0]     ptr_addr,
  output logic              wb_en,
  output logic [AW-1:0]     wb_data
);
  logic [AW-1:0] pc_ofs_x, disp_x, pc_sum;

  ea_sext #(.IN_W(PCOFS_W), .OUT_W(AW)) u_sx_pc  (.din(pc_ofs), .dout(pc_ofs_x));
  ea_sext #(.IN_W(DISP_W),  .OUT_W(AW)) u_sx_dsp (.din(disp),   .dout(disp_x));

  assign pc_sum   = pc_next + pc_ofs_x;
  assign ptr_addr = pc_sum;
  assign wb_data  = base_val + AW'(OP_SIZE);

  always_comb begin
    result   = '0;
    loc      = LOC_MEM;
    bad      = 1'b0;
    indirect = 1'b0;
    wb_en    = 1'b0;
    case (mode)
      M_REG: begin
        result = AW'(base_sel);
        loc    = LOC_REG;
      end
      M_IMM: begin
        result = imm_val;
        loc    = LOC_INSN;
      end
      M_RIND: result = base_val;
      M_BDSP: result = base_val + disp_x;
      M_ABS:  result = abs_addr;
      M_PCR:  result = pc_sum;
      M_IDX:  result = base_val + index_val;
      M_AINC: begin
        result = base_val;
        wb_en  = 1'b1;
      end
      M_MIND: indirect = 1'b1;
      default: begin
        bad = 1'b1;
        loc = LOC_REG;
      end
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     c_result,
  input  loc_e              c_loc,
  input  logic              c_bad,
  input  logic              c_indirect,
  input  logic [AW-1:0]     c_ptr,
  input  logic              c_wb_en,
  input  logic [AW-1:0]     c_wb_data,
  input  logic [RSEL_W-1:0] base_sel,
  input  logic              mem_valid,
  input  logic [AW-1:0]     mem_rdata,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        loc,
  output logic [AW-1:0]     result,
  output logic              wb_en,
  output logic [RSEL_W-1:0] wb_sel,
  output logic [AW-1:0]     wb_data
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      loc      <= 2'd0;
      result   <= '0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      wb_data  <= '0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      wb_en <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (c_indirect) begin
              st       <= S_WAIT;
              mem_req  <= 1'b1;
              mem_addr <= c_ptr;
              busy     <= 1'b1;
            end else begin
              done    <= 1'b1;
              err     <= c_bad;
              loc     <= c_loc;
              result  <= c_result;
              wb_en   <= c_wb_en;
              wb_sel  <= base_sel;
              wb_data <= c_wb_data;
            end
          end
        end
        S_WAIT: begin
          if (mem_valid) begin
            st      <= S_IDLE;
            mem_req <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b1;
            loc     <= LOC_MEM;
            result  <= mem_rdata;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW      = 16,
  parameter int PCOFS_W = 9,
  parameter int DISP_W  = 6,
  parameter int RSEL_W  = 3,
  parameter int OP_SIZE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [RSEL_W-1:0] base_sel,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     index_val,
  input  logic [AW-1:0]     pc_next,
  input  logic [PCOFS_W-1:0] pc_ofs,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     abs_addr,
  input  logic [AW-1:0]     imm_val,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_valid,
  input  logic [AW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        loc,
  output logic [AW-1:0]     result,
  output logic              wb_en,
  output logic [RSEL_W-1:0] wb_sel,
  output logic [AW-1:0]     wb_data
);
  logic [AW-1:0] c_result, c_ptr, c_wb_data;
  loc_e          c_loc;
  logic          c_bad, c_indirect, c_wb_en;

  ea_calc #(
    .AW(AW), .PCOFS_W(PCOFS_W), .DISP_W(DISP_W), .RSEL_W(RSEL_W), .OP_SIZE(OP_SIZE)
  ) u_calc (
    .mode(mode), .base_sel(base_sel), .base_val(base_val), .index_val(index_val),
    .pc_next(pc_next), .pc_ofs(pc_ofs), .disp(disp), .abs_addr(abs_addr),
    .imm_val(imm_val), .result(c_result), .loc(c_loc), .bad(c_bad),
    .indirect(c_indirect), .ptr_addr(c_ptr), .wb_en(c_wb_en), .wb_data(c_wb_data)
  );

  ea_ctrl #(.AW(AW), .RSEL_W(RSEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .c_result(c_result), .c_loc(c_loc), .c_bad(c_bad), .c_indirect(c_indirect),
    .c_ptr(c_ptr), .c_wb_en(c_wb_en), .c_wb_data(c_wb_data), .base_sel(base_sel),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy), .done(done), .err(err),
    .loc(loc), .result(result), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
  );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_valid,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          wb_en
);
  // R1: nothing active in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!done && !busy && !mem_req && !wb_en && !err));

  // R10: request only while a pointer read is outstanding
  a_r10_req_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R10: request and address hold until valid
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R10: done follows a sampled valid
  a_r10_done_after_valid: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_valid) |=> (done && !busy && !mem_req));

  // R11: error only reported with done
  a_r11_err_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R9: write-back only with done
  a_r9_wb_done: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_valid(mem_valid), .busy(busy), .done(done), .err(err), .wb_en(wb_en)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [2:0]  base_sel = '0;
  logic [15:0] base_val = '0, index_val = '0, pc_next = '0, abs_addr = '0, imm_val = '0;
  logic [8:0]  pc_ofs = '0;
  logic [5:0]  disp = '0;
  logic        mem_req, mem_valid = 1'b0;
  logic [15:0] mem_addr, mem_rdata = '0;
  logic        busy, done, err, wb_en;
  logic [1:0]  loc;
  logic [15:0] result, wb_data;
  logic [2:0]  wb_sel;

  int n_chk = 0, n_bad = 0, n_req = 0, wait_cnt = 0, cyc = 0;
  logic [15:0] addr_seen;

  always #10 clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base_sel(base_sel),
    .base_val(base_val), .index_val(index_val), .pc_next(pc_next), .pc_ofs(pc_ofs),
    .disp(disp), .abs_addr(abs_addr), .imm_val(imm_val), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .err(err), .loc(loc), .result(result), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_data(wb_data)
  );

  typedef struct packed {
    logic [15:0] res;
    logic [1:0]  lc;
    logic        er;
    logic        we;
    logic [2:0]  ws;
    logic [15:0] wd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return a ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: valid after three cycles of request
  always @(negedge clk) begin
    cyc++;
    if (mem_valid) begin
      mem_valid <= 1'b0;
      wait_cnt  <= 0;
    end else if (mem_req) begin
      if (wait_cnt > 0)
        check(mem_addr == addr_seen, "R10 address hold", 64'(mem_addr), 64'(addr_seen));
      addr_seen <= mem_addr;
      if (wait_cnt == 0) n_req++;
      if (wait_cnt == 2) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem_word(mem_addr);
      end
      wait_cnt <= wait_cnt + 1;
    end
  end

  // monitor: pop one expectation per done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected done", 64'(result), 64'(0));
      end else begin
        exp_t  e;
        exp_t  a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{res: result, lc: loc, er: err, we: wb_en,
              ws: (wb_en ? wb_sel : 3'd0), wd: (wb_en ? wb_data : 16'd0)};
        check(a == e, t, 64'(a), 64'(e));
      end
    end
  end

  task automatic issue(input logic [3:0] m, input logic [2:0] bs, input logic [15:0] bv, iv, pc,
                       input logic [8:0] po, input logic [5:0] dp, input logic [15:0] ab, im,
                       input exp_t e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    mode = m; base_sel = bs; base_val = bv; index_val = iv; pc_next = pc;
    pc_ofs = po; disp = dp; abs_addr = ab; imm_val = im;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic exp_t mk(input logic [15:0] r, input logic [1:0] l,
                              input logic er = 1'b0, input logic we = 1'b0,
                              input logic [2:0] ws = 3'd0, input logic [15:0] wd = 16'd0);
    exp_t e;
    e = '{res: r, lc: l, er: er, we: we, ws: ws, wd: wd};
    return e;
  endfunction

  initial begin
    fork
      begin
        wait (cyc > 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    check(!done && !busy && !mem_req && !wb_en && !err, "R1 reset state",
          64'({done, busy, mem_req, wb_en, err}), 64'(0));

    // R2 register mode
    issue(4'd0, 3'd5, 16'h1234, 16'h0, 16'h0, 9'd0, 6'd0, 16'h0, 16'h0,
          mk(16'd5, 2'd0), "R2 register");
    // R3 immediate
    issue(4'd1, 3'd1, 16'h0, 16'h0, 16'h0, 9'd0, 6'd0, 16'h0, 16'hBEEF,
          mk(16'hBEEF, 2'd1), "R3 immediate");
    check(n_req == 0, "R2 R3 no memory request", 64'(n_req), 64'(0));
    // R4 register indirect
    issue(4'd2, 3'd2, 16'h4000, 16'h0, 16'h0, 9'd0, 6'h3F, 16'h0, 16'h0,
          mk(16'h4000, 2'd2), "R4 register indirect");
    // R5 positive and negative displacement, wrap
    issue(4'd3, 3'd3, 16'h1000, 16'h0, 16'h0, 9'd0, 6'd31, 16'h0, 16'h0,
          mk(16'h101F, 2'd2), "R5 disp +31");
    issue(4'd3, 3'd3, 16'h0001, 16'h0, 16'h0, 9'd0, 6'h20, 16'h0, 16'h0,
          mk(16'hFFE1, 2'd2), "R5 disp -32 wrap");
    // R6 absolute
    issue(4'd4, 3'd0, 16'h7777, 16'h0, 16'h0, 9'd0, 6'd0, 16'hC0DE, 16'h0,
          mk(16'hC0DE, 2'd2), "R6 absolute");
    // R7 PC-relative
    issue(4'd5, 3'd0, 16'h0, 16'h0, 16'h3000, 9'd255, 6'd0, 16'h0, 16'h0,
          mk(16'h30FF, 2'd2), "R7 pcrel +255");
    issue(4'd5, 3'd0, 16'h0, 16'h0, 16'h3000, 9'h100, 6'd0, 16'h0, 16'h0,
          mk(16'h2F00, 2'd2), "R7 pcrel -256");
    // R8 indexed
    issue(4'd6, 3'd4, 16'hF000, 16'h1234, 16'h0, 9'd0, 6'd0, 16'h0, 16'h0,
          mk(16'h0234, 2'd2), "R8 indexed wrap");
    // R9 auto-increment
    issue(4'd7, 3'd6, 16'h5555, 16'h0, 16'h0, 9'd0, 6'd0, 16'h0, 16'h0,
          mk(16'h5555, 2'd2, 1'b0, 1'b1, 3'd6, 16'h5556), "R9 autoinc");
    issue(4'd7, 3'd7, 16'hFFFF, 16'h0, 16'h0, 9'd0, 6'd0, 16'h0, 16'h0,
          mk(16'hFFFF, 2'd2, 1'b0, 1'b1, 3'd7, 16'h0000), "R9 autoinc wrap");
    // R11 unused codes
    issue(4'd9, 3'd1, 16'h1111, 16'h0, 16'h0, 9'd0, 6'd0, 16'h0, 16'h0,
          mk(16'h0, 2'd0, 1'b1), "R11 code 9");
    issue(4'd15, 3'd1, 16'h1111, 16'h0, 16'h0, 9'd0, 6'd0, 16'h0, 16'h0,
          mk(16'h0, 2'd0, 1'b1), "R11 code 15");
    check(n_req == 0, "R11 no memory request", 64'(n_req), 64'(0));

    // R10 memory indirect, with a start during busy (R12)
    exp_q.push_back(mk(mem_word(16'h2010), 2'd2));
    tag_q.push_back("R10 memory indirect");
    mode = 4'd8; pc_next = 16'h2000; pc_ofs = 9'h010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(mem_req && busy && mem_addr == 16'h2010, "R10 request one cycle after start",
          64'({mem_req, busy, mem_addr}), 64'({2'b11, 16'h2010}));
    mode = 4'd0; start = 1'b1;   // R12: ignored
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(!busy && !mem_req, "R10 idle after completion", 64'({busy, mem_req}), 64'(0));
    check(n_req == 1, "R10 single pointer read", 64'(n_req), 64'(1));

    // R10 negative offset
    exp_q.push_back(mk(mem_word(16'h1FFF), 2'd2));
    tag_q.push_back("R10 memory indirect negative");
    mode = 4'd8; pc_next = 16'h2000; pc_ofs = 9'h1FF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);

    check(exp_q.size() == 0, "R12 all results seen", 64'(exp_q.size()), 64'(0));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule